// File: doc/BRIEF.md
# Pending-Write Hazard Scoreboard Queue

This block sits between the execution stage and the memory-store stage of a decoupled processor back end. When the issue logic launches an operation, it names the destination address and a small tag for that operation. Later, the execution stage hands back the result under the same tag. The result then enters an in-order queue, where it waits until the store stage writes it out. The store stage always sees the oldest queued result at the head, and signals completion to retire it.

While a write is pending, either as an issued operation that has not yet produced its result or as a result that has not yet been stored, two upstream stages must not touch that address. These stages are the instruction prefetcher and the operand reader. Each stage has its own lookup port. In the same cycle, the port compares its address against every in-flight tag and every live queue entry, and raises a stall flag without a register in between. Several pending writes to one address may coexist, and the stall lasts until the last of them retires. The queue never drops a result: when it is full, it holds the result producer off with a ready flag.

Top module: `hz_scoreboard_q`

## Requirements
- R1: While reset is asserted and after it is released, the queue is empty (`hd_vld` low), `res_rdy` is high, and neither stall flag is high.
- R2: An accepted issue on `iss_tag` makes its address stall a matching lookup on either port from the cycle after the issue clock edge. The address does not stall a lookup in the issue cycle itself.
- R3: After a tag's result is pushed, its address keeps stalling matching lookups without a gap, because the address now sits in the queue.
- R4: The head (`hd_addr`, `hd_data`) always shows the oldest stored-pending result. It changes only on a store completion or when a push lands in an empty queue.
- R5: In the cycle `st_done` is high while `hd_vld` is high, the head entry no longer causes a stall. The next entry becomes the head after that clock edge.
- R6: With several pending writes to one address, the stall holds until the last of them has retired.
- R7: `res_rdy` is low while the queue holds DEPTH entries, and a push offered then is not accepted. Its tag stays in flight, and the queued entries later drain intact and in order.
- R8: `st_done` while the queue is empty has no effect. A later push becomes the head normally.
- R9: An issue to a tag that is still in flight is ignored. The old address keeps stalling, and the new address does not stall.
- R10: A lookup port whose request input is low never stalls, whatever its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Issue notification valid |
| iss_tag | input | $clog2(TAGS) | Tag of the issued operation |
| iss_addr | input | AW | Destination address of the issued operation |
| res_vld | input | 1 | Result push valid |
| res_tag | input | $clog2(TAGS) | Tag whose result is pushed |
| res_data | input | DW | Result value |
| res_rdy | output | 1 | Queue can accept a push this cycle |
| st_done | input | 1 | Store stage finished writing the head entry |
| hd_vld | output | 1 | Head entry present |
| hd_addr | output | AW | Head entry destination address |
| hd_data | output | DW | Head entry result value |
| fch_req | input | 1 | Prefetch lookup request |
| fch_addr | input | AW | Prefetch lookup address |
| fch_stall | output | 1 | Prefetch must stall |
| opr_req | input | 1 | Operand-read lookup request |
| opr_addr | input | AW | Operand-read lookup address |
| opr_stall | output | 1 | Operand read must stall |

## Verification
A lost in-flight tag or a live bit left set on a retired queue slot shows up in the very next lookup of that address. The lost tag lets a dependent read through, and the stale live bit gives a stall that never clears. A read or write pointer that is off by one, or an occupancy count that is wrong, shows up at the head within one store completion: the head presents a wrong address or value, presents nothing too early, or reports readiness while full. The bench therefore probes the stall flags at both the issue edge and the retire edge, and it drains a full queue entry by entry against the order in which the results were pushed.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NPORT      = 2;
  localparam int PORT_FETCH = 0;
  localparam int PORT_OPND  = 1;

  // occupancy after one cycle of optional insert and removal
  function automatic int occ_next(input int occ, input logic ins, input logic rem);
    return occ + (ins ? 1 : 0) - (rem ? 1 : 0);
  endfunction
endpackage

// File: rtl/hz_tag_table.sv
module hz_tag_table #(
  parameter int TAGS = 4,
  parameter int AW   = 8,
  localparam int TW  = $clog2(TAGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_vld,
  input  logic [TW-1:0]            iss_tag,
  input  logic [AW-1:0]            iss_addr,
  input  logic                     clr_vld,
  input  logic [TW-1:0]            clr_tag,
  output logic                     iss_acc,
  output logic [AW-1:0]            clr_addr,
  output logic [TAGS-1:0]          busy,
  output logic [TAGS-1:0][AW-1:0]  addr
);
  logic slot_freed;

  assign slot_freed = clr_vld && (clr_tag == iss_tag);
  assign iss_acc    = iss_vld && (!busy[iss_tag] || slot_freed);
  assign clr_addr   = addr[clr_tag];

  for (genvar i = 0; i < TAGS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[i] <= 1'b0;
        addr[i] <= '0;
      end else if (iss_acc && iss_tag == TW'(i)) begin
        busy[i] <= 1'b1;
        addr[i] <= iss_addr;
      end else if (clr_vld && clr_tag == TW'(i)) begin
        busy[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hz_result_fifo.sv
module hz_result_fifo #(
  parameter int DEPTH = 20,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop_req,
  output logic                      rdy,
  output logic                      push_acc,
  output logic                      pop_acc,
  output logic                      hd_vld,
  output logic [AW-1:0]             hd_addr,
  output logic [DW-1:0]             hd_data,
  output logic [CW-1:0]             count,
  output logic [DEPTH-1:0]          ent_live,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr
);
  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [DEPTH-1:0] held;
  logic [AW-1:0]    mem_a [DEPTH];
  logic [DW-1:0]    mem_d [DEPTH];

  assign rdy      = (count != CW'(DEPTH));
  assign hd_vld   = (count != '0);
  assign push_acc = push && rdy;
  assign pop_acc  = pop_req && hd_vld;
  assign hd_addr  = mem_a[rd_ptr];
  assign hd_data  = mem_d[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_acc) wr_ptr <= step_ptr(wr_ptr);
      if (pop_acc)  rd_ptr <= step_ptr(rd_ptr);
      count <= CW'(hz_pkg::occ_next(int'(count), push_acc, pop_acc));
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic wr_here, rd_here;
    assign wr_here = push_acc && (wr_ptr == PW'(i));
    assign rd_here = pop_acc && (rd_ptr == PW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[i] <= 1'b0;
      else if (wr_here) held[i] <= 1'b1;
      else if (rd_here) held[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_a[i] <= '0;
        mem_d[i] <= '0;
      end else if (wr_here) begin
        mem_a[i] <= push_addr;
        mem_d[i] <= push_data;
      end
    end

    // an entry being retired this cycle no longer blocks anybody
    assign ent_live[i] = held[i] && !rd_here;
    assign ent_addr[i] = mem_a[i];
  end
endmodule

// File: rtl/hz_addr_cam.sv
module hz_addr_cam #(
  parameter int N  = 24,
  parameter int AW = 8
) (
  input  logic                 req,
  input  logic [AW-1:0]        key,
  input  logic [N-1:0]         live,
  input  logic [N-1:0][AW-1:0] addr,
  output logic                 hit
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = live[i] && (addr[i] == key);
  end

  assign hit = req && (|eq);
endmodule

// File: rtl/hz_scoreboard_q.sv
module hz_scoreboard_q #(
  parameter int DEPTH = 20,
  parameter int TAGS  = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_vld,
  input  logic [$clog2(TAGS)-1:0]  iss_tag,
  input  logic [AW-1:0]            iss_addr,
  input  logic                     res_vld,
  input  logic [$clog2(TAGS)-1:0]  res_tag,
  input  logic [DW-1:0]            res_data,
  output logic                     res_rdy,
  input  logic                     st_done,
  output logic                     hd_vld,
  output logic [AW-1:0]            hd_addr,
  output logic [DW-1:0]            hd_data,
  input  logic                     fch_req,
  input  logic [AW-1:0]            fch_addr,
  output logic                     fch_stall,
  input  logic                     opr_req,
  input  logic [AW-1:0]            opr_addr,
  output logic                     opr_stall
);
  import hz_pkg::*;

  localparam int TW   = $clog2(TAGS);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int NCMP = TAGS + DEPTH;

  // named internal events, also observed by the checker
  logic                     iss_acc;
  logic                     res_acc;
  logic                     pop_acc;
  logic [AW-1:0]            res_addr;
  logic [TAGS-1:0]          tag_busy;
  logic [TAGS-1:0][AW-1:0]  tag_addr;
  logic [CW-1:0]            q_count;
  logic [DEPTH-1:0]         q_live;
  logic [DEPTH-1:0][AW-1:0] q_addr;

  hz_tag_table #(.TAGS(TAGS), .AW(AW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_vld  (iss_vld),
    .iss_tag  (iss_tag),
    .iss_addr (iss_addr),
    .clr_vld  (res_acc),
    .clr_tag  (res_tag),
    .iss_acc  (iss_acc),
    .clr_addr (res_addr),
    .busy     (tag_busy),
    .addr     (tag_addr)
  );

  hz_result_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (res_vld),
    .push_addr (res_addr),
    .push_data (res_data),
    .pop_req   (st_done),
    .rdy       (res_rdy),
    .push_acc  (res_acc),
    .pop_acc   (pop_acc),
    .hd_vld    (hd_vld),
    .hd_addr   (hd_addr),
    .hd_data   (hd_data),
    .count     (q_count),
    .ent_live  (q_live),
    .ent_addr  (q_addr)
  );

  logic [NCMP-1:0]          cmp_live;
  logic [NCMP-1:0][AW-1:0]  cmp_addr;
  assign cmp_live = {q_live, tag_busy};
  assign cmp_addr = {q_addr, tag_addr};

  logic [NPORT-1:0]          lk_req;
  logic [NPORT-1:0][AW-1:0]  lk_addr;
  logic [NPORT-1:0]          lk_stall;

  assign lk_req[PORT_FETCH]  = fch_req;
  assign lk_addr[PORT_FETCH] = fch_addr;
  assign lk_req[PORT_OPND]   = opr_req;
  assign lk_addr[PORT_OPND]  = opr_addr;
  assign fch_stall = lk_stall[PORT_FETCH];
  assign opr_stall = lk_stall[PORT_OPND];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    hz_addr_cam #(.N(NCMP), .AW(AW)) u_cam (
      .req  (lk_req[p]),
      .key  (lk_addr[p]),
      .live (cmp_live),
      .addr (cmp_addr),
      .hit  (lk_stall[p])
    );
  end
endmodule

// File: rtl/hz_scoreboard_q_chk.sv
module hz_scoreboard_q_chk #(
  parameter int DEPTH = 20,
  parameter int TAGS  = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     iss_acc,
  input logic [$clog2(TAGS)-1:0]  iss_tag,
  input logic [TAGS-1:0]          tag_busy,
  input logic                     res_acc,
  input logic                     res_rdy,
  input logic                     st_done,
  input logic                     hd_vld,
  input logic [AW-1:0]            hd_addr,
  input logic [DW-1:0]            hd_data,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                     fch_stall,
  input logic                     opr_stall
);
  // R1: everything is clear while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (!hd_vld && res_rdy && !fch_stall && !opr_stall)
        else $error("R1 state not clear during reset");
    end
  end

  // R2: an accepted issue leaves its tag in flight
  a_r2_issue_tracked: assert property (@(posedge clk) disable iff (!rst_n)
    iss_acc |=> tag_busy[$past(iss_tag)]);

  // R3: a stall always has a pending write behind it
  a_r3_stall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_stall || opr_stall) |-> ((|tag_busy) || hd_vld));

  // R4: the head holds still until the store stage retires it
  a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_vld && !st_done) |=> (hd_vld && $stable(hd_addr) && $stable(hd_data)));

  // R7: occupancy bounded, and full stays full without a retire
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH+1))'(DEPTH));
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_rdy && !st_done) |=> !res_rdy);

  // R8: retiring from an empty queue leaves it empty
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && !hd_vld && !res_acc) |=> !hd_vld);
endmodule

bind hz_scoreboard_q hz_scoreboard_q_chk #(
  .DEPTH(DEPTH), .TAGS(TAGS), .AW(AW), .DW(DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_acc   (iss_acc),
  .iss_tag   (iss_tag),
  .tag_busy  (tag_busy),
  .res_acc   (res_acc),
  .res_rdy   (res_rdy),
  .st_done   (st_done),
  .hd_vld    (hd_vld),
  .hd_addr   (hd_addr),
  .hd_data   (hd_data),
  .q_count   (q_count),
  .fch_stall (fch_stall),
  .opr_stall (opr_stall)
);

// File: tb/sim_hz_scoreboard_q.sv
module sim_hz_scoreboard_q;
  localparam int CLK_P = 10;
  localparam int DEPTH = 20;
  localparam int TAGS  = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_vld = 0, res_vld = 0, st_done = 0, fch_req = 0, opr_req = 0;
  logic [1:0] iss_tag = '0, res_tag = '0;
  logic [AW-1:0] iss_addr = '0, fch_addr = '0, opr_addr = '0;
  logic [DW-1:0] res_data = '0;
  logic res_rdy, hd_vld, fch_stall, opr_stall;
  logic [AW-1:0] hd_addr;
  logic [DW-1:0] hd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hz_scoreboard_q #(.DEPTH(DEPTH), .TAGS(TAGS), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_addr(iss_addr),
    .res_vld(res_vld), .res_tag(res_tag), .res_data(res_data), .res_rdy(res_rdy),
    .st_done(st_done), .hd_vld(hd_vld), .hd_addr(hd_addr), .hd_data(hd_data),
    .fch_req(fch_req), .fch_addr(fch_addr), .fch_stall(fch_stall),
    .opr_req(opr_req), .opr_addr(opr_addr), .opr_stall(opr_stall)
  );

  // lookup vectors: {fetch addr, operand addr, expected fetch stall, expected operand stall}
  // pending at the time of the walk: 8'h11 and 8'h22 (R2)
  localparam logic [17:0] LK_TBL [6] = '{
    {8'h11, 8'h22, 1'b1, 1'b1},
    {8'h33, 8'h11, 1'b0, 1'b1},
    {8'h22, 8'h44, 1'b1, 1'b0},
    {8'h00, 8'hFF, 1'b0, 1'b0},
    {8'h12, 8'h21, 1'b0, 1'b0},
    {8'h22, 8'h11, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_issue(input logic [1:0] tag, input logic [AW-1:0] a);
    iss_vld = 1; iss_tag = tag; iss_addr = a;
    cyc();
    iss_vld = 0;
  endtask

  task automatic do_push(input logic [1:0] tag, input logic [DW-1:0] d);
    res_vld = 1; res_tag = tag; res_data = d;
    cyc();
    res_vld = 0;
  endtask

  task automatic do_retire();
    st_done = 1;
    cyc();
    st_done = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected end of test");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    fch_req = 1; fch_addr = 8'h00; opr_req = 1; opr_addr = 8'h11;
    repeat (3) cyc();
    #1;
    chk(!hd_vld, "R1 hd_vld in reset", 32'(hd_vld), 0);
    chk(res_rdy, "R1 res_rdy in reset", 32'(res_rdy), 1);
    chk(!fch_stall && !opr_stall, "R1 stalls in reset", 32'({fch_stall, opr_stall}), 0);
    cyc();
    rst_n = 1;
    cyc();
    #1;
    chk(!hd_vld && res_rdy && !fch_stall && !opr_stall, "R1 after release",
        32'({hd_vld, res_rdy, fch_stall, opr_stall}), 32'b0100);

    // R2: issue tag0 at 0x11; no stall in the issue cycle itself
    iss_vld = 1; iss_tag = 2'd0; iss_addr = 8'h11;
    fch_addr = 8'h11;
    #1;
    chk(!fch_stall, "R2 no stall in issue cycle", 32'(fch_stall), 0);
    cyc();
    iss_vld = 0;
    // R10: request low hides the match
    fch_req = 0; opr_req = 1; opr_addr = 8'h11;
    #1;
    chk(!fch_stall, "R10 no stall without request", 32'(fch_stall), 0);
    chk(opr_stall, "R2 stall after issue", 32'(opr_stall), 1);
    fch_req = 1;

    do_issue(2'd1, 8'h22);

    // R2: table walk over both ports
    for (int i = 0; i < 6; i++) begin
      fch_addr = LK_TBL[i][17:10];
      opr_addr = LK_TBL[i][9:2];
      #1;
      chk(fch_stall == LK_TBL[i][1], "R2 fetch lookup", 32'(fch_stall), 32'(LK_TBL[i][1]));
      chk(opr_stall == LK_TBL[i][0], "R2 operand lookup", 32'(opr_stall), 32'(LK_TBL[i][0]));
      cyc();
    end

    // R9: reissue to busy tag0 is ignored
    do_issue(2'd0, 8'h55);
    fch_addr = 8'h55; opr_addr = 8'h11;
    #1;
    chk(!fch_stall, "R9 new address on busy tag", 32'(fch_stall), 0);
    chk(opr_stall, "R9 old address still pending", 32'(opr_stall), 1);

    // R3/R4: push tag0 result
    fch_addr = 8'h11;
    res_vld = 1; res_tag = 2'd0; res_data = 16'hA0A0;
    #1;
    chk(res_rdy && fch_stall, "R3 stall during push cycle", 32'({res_rdy, fch_stall}), 32'b11);
    cyc();
    res_vld = 0;
    #1;
    chk(fch_stall, "R3 stall after push", 32'(fch_stall), 1);
    chk(hd_vld && hd_addr == 8'h11 && hd_data == 16'hA0A0, "R4 head after first push",
        32'({hd_addr, hd_data}), 32'h0011A0A0);

    do_push(2'd1, 16'hB1B1);
    #1;
    chk(hd_addr == 8'h11, "R4 head keeps oldest", 32'(hd_addr), 32'h11);

    // R5: retire releases the head in the same cycle
    opr_addr = 8'h22;
    st_done = 1;
    #1;
    chk(!fch_stall, "R5 head released in retire cycle", 32'(fch_stall), 0);
    chk(opr_stall, "R5 next entry still pending", 32'(opr_stall), 1);
    cyc();
    st_done = 0;
    #1;
    chk(hd_vld && hd_addr == 8'h22 && hd_data == 16'hB1B1, "R4 head advances in order",
        32'({hd_addr, hd_data}), 32'h0022B1B1);
    do_retire();
    #1;
    chk(!hd_vld && !opr_stall, "R5 queue empty after retire", 32'({hd_vld, opr_stall}), 0);

    // R8: retire on empty queue
    do_retire();
    #1;
    chk(!hd_vld && res_rdy, "R8 empty retire ignored", 32'({hd_vld, res_rdy}), 32'b01);

    // R6: two pending writes to 0x77
    do_issue(2'd2, 8'h77);
    do_issue(2'd3, 8'h77);
    do_push(2'd2, 16'h0007);
    #1;
    chk(hd_vld && hd_addr == 8'h77, "R8 push after empty retire", 32'(hd_addr), 32'h77);
    fch_addr = 8'h77;
    do_retire();
    #1;
    chk(fch_stall, "R6 stall while second write in flight", 32'(fch_stall), 1);
    do_push(2'd3, 16'h0008);
    #1;
    chk(fch_stall, "R6 stall while second write queued", 32'(fch_stall), 1);
    do_retire();
    #1;
    chk(!fch_stall && !hd_vld, "R6 stall cleared after last write", 32'({fch_stall, hd_vld}), 0);

    // R7: fill the queue
    for (int k = 0; k < DEPTH; k++) begin
      do_issue(2'd0, AW'(8'h80 + k));
      do_push(2'd0, DW'(16'h1000 + k));
    end
    #1;
    chk(!res_rdy, "R7 ready low when full", 32'(res_rdy), 0);
    do_issue(2'd1, 8'hEE);
    res_vld = 1; res_tag = 2'd1; res_data = 16'hEEEE;
    cyc();
    res_vld = 0;
    #1;
    chk(hd_addr == 8'h80 && hd_data == 16'h1000, "R7 head intact after refused push",
        32'({hd_addr, hd_data}), 32'h00801000);
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      chk(hd_vld && hd_addr == AW'(8'h80 + k) && hd_data == DW'(16'h1000 + k), "R7 drain order",
          32'({hd_addr, hd_data}), 32'({AW'(8'h80 + k), DW'(16'h1000 + k)}));
      do_retire();
    end
    #1;
    chk(!hd_vld, "R7 no extra entry after drain", 32'(hd_vld), 0);
    fch_addr = 8'hEE;
    #1;
    chk(fch_stall, "R7 refused result still in flight", 32'(fch_stall), 1);
    do_push(2'd1, 16'hEEEE);
    #1;
    chk(hd_vld && hd_addr == 8'hEE && hd_data == 16'hEEEE, "R7 refused result pushed later",
        32'({hd_addr, hd_data}), 32'h00EEEEEE);

    done = 1;
    finish_run();
  end
endmodule